// File: doc/BRIEF.md
# Crosspoint Routing Configuration Slave

This block is the control side of an eight-input, six-output video crosspoint. It is a write-only two-wire serial (I2C) target. It samples SCL and SDA with the system clock, finds START and STOP conditions, and compares the first byte of a transfer with its device address. Two strap pins set the top two bits of that address. A transfer that matches carries a register pointer byte and then one or more data bytes. These bytes load five configuration registers.

The registers are decoded continuously into control lines for the analog side. Each output gets an input-select code and a driver enable; a disabled driver stands for a powered-down, high-impedance output stage. Each input gets a clamp or bias flag, and each output gets a gain flag. Reads, clock stretching and fast-mode timing are not supported. The design targets standard-mode bit rates, which are far slower than the system clock.

Top module: `xbar_cfg_slave`

## Requirements
- R1: The device address byte is {strap_hi, strap_lo, 6'b000110}, so the 8-bit address byte is 0x06, 0x46, 0x86 or 0xC6. The slave ACKs only that byte with bit 0 (read/write) at 0. A read request or any other address gets no ACK, and the rest of that transfer changes no register.
- R2: After reset every register is 0. All out_en bits are 0, out_sel is all zero, in_clamp is 0 (bias), out_gain0db is 0 (6 dB) and sda_oe is 0.
- R3: Register 0x00 holds the selects for outputs 1 and 2, 0x01 for outputs 3 and 4, and 0x02 for outputs 5 and 6. The lower-numbered output takes bits 3:0 and the higher-numbered output takes bits 7:4. Output k appears at out_sel[4k-1:4k-4] and out_en[k-1].
- R4: A select code of 1 to 8 routes input 1 to 8 and sets the enable, and any number of outputs may use the same input. Code 0 and codes 9 to 15 clear the enable and show out_sel as 0.
- R5: Register 0x03 bit n-1 drives in_clamp[n-1] for input n. A 1 selects clamp and a 0 selects bias.
- R6: Register 0x04 bits 5:0 drive out_gain0db[5:0] for outputs 1 to 6. A 1 selects 0 dB and a 0 selects 6 dB. Bits 7:6 of the data byte have no effect.
- R7: Data bytes sent to pointer values above 0x04 are ACKed and change no output.
- R8: After each data byte the pointer advances by one, so several data bytes in one transfer fill consecutive registers.
- R9: A repeated START ends the current byte, even one cut off part-way, and the next byte is taken as a device address.
- R10: sda_oe is asserted only in the ACK bit slot: it rises after the SCL fall that ends the eighth bit and clears at the next SCL fall. It is never asserted while a data bit is on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line, sampled |
| sda_i | input | 1 | Serial data line, sampled |
| strap_hi | input | 1 | Address strap, sets address-byte bit 7 |
| strap_lo | input | 1 | Address strap, sets address-byte bit 6 |
| sda_oe | output | 1 | 1 pulls SDA low (ACK) |
| out_sel | output | 24 | Per-output input number, 4 bits per output, 0 when off |
| out_en | output | 6 | Per-output driver enable |
| in_clamp | output | 8 | Per-input mode, 1 clamp, 0 bias |
| out_gain0db | output | 6 | Per-output gain, 1 is 0 dB, 0 is 6 dB |

## Verification
Both bus lines pass through the same two-stage synchronizer, so an SCL edge reaches the byte engine three system clocks after the pin changes. The ACK drive starts one clock after that detection. A register write is strobed on the SCL fall that ends the eighth data bit and appears on the decoded outputs two clocks later. The bench samples ACK halfway through the high phase of the ninth SCL pulse, which is ten clocks after the edge. It checks the decoded outputs only after STOP plus eight clocks, so every result is settled long before it is read. A monitor flags any cycle in which sda_oe is high while the bench holds SCL high for a data bit.

// File: rtl/xbar_cfg_pkg.sv
// Shared types for the crosspoint configuration slave.
package xbar_cfg_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_RX, ST_ACK} link_st_t;
    typedef enum logic [1:0] {PH_DEV, PH_PTR, PH_DATA} byte_ph_t;
endpackage

// File: rtl/xbar_line_sync.sv
// Synchronises SCL/SDA to clk and produces single-cycle edge and
// START/STOP pulses. Assumes the bus is many clk periods per bit.
module xbar_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_bit,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_m, scl_s, scl_q;
    logic sda_m, sda_s, sda_q;

    // Two-flop synchroniser plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {scl_m, scl_s, scl_q} <= 3'b111;
            {sda_m, sda_s, sda_q} <= 3'b111;
        end else begin
            {scl_m, scl_s, scl_q} <= {scl_i, scl_m, scl_s};
            {sda_m, sda_s, sda_q} <= {sda_i, sda_m, sda_s};
        end
    end

    assign sda_bit   = sda_s;
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/xbar_wr_engine.sv
// Byte engine of the write-only serial target: shifts bits in on SCL
// rise, decides ACK on the SCL fall ending bit 8, drives ACK for one
// bit slot, and strobes one register write per data byte. Assumes
// edge pulses from xbar_line_sync.
module xbar_wr_engine
    import xbar_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [6:0] dev_addr,
    input  logic       sda_bit,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    output logic       sda_oe,
    output logic       wr_stb,
    output logic [7:0] wr_addr,
    output logic [7:0] wr_data
);
    link_st_t   st;
    byte_ph_t   ph;
    logic [3:0] bitcnt;
    logic [7:0] shreg;
    logic [7:0] ptr;

    // Bus state machine: receive, acknowledge, write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            ph      <= PH_DEV;
            bitcnt  <= '0;
            shreg   <= '0;
            ptr     <= '0;
            sda_oe  <= 1'b0;
            wr_stb  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_stb <= 1'b0;
            if (start_det) begin
                st     <= ST_RX;
                ph     <= PH_DEV;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else if (stop_det) begin
                st     <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (st)
                    ST_RX: begin
                        if (scl_rise && bitcnt != 4'd8) begin
                            shreg  <= {shreg[6:0], sda_bit};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall && bitcnt == 4'd8) begin
                            case (ph)
                                PH_DEV: begin
                                    if (shreg[7:1] == dev_addr && !shreg[0]) begin
                                        ph     <= PH_PTR;
                                        sda_oe <= 1'b1;
                                        st     <= ST_ACK;
                                    end else begin
                                        st <= ST_IDLE;
                                    end
                                end
                                PH_PTR: begin
                                    ptr    <= shreg;
                                    ph     <= PH_DATA;
                                    sda_oe <= 1'b1;
                                    st     <= ST_ACK;
                                end
                                default: begin
                                    wr_stb  <= 1'b1;
                                    wr_addr <= ptr;
                                    wr_data <= shreg;
                                    ptr     <= ptr + 8'd1;
                                    sda_oe  <= 1'b1;
                                    st      <= ST_ACK;
                                end
                            endcase
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            bitcnt <= '0;
                            st     <= ST_RX;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R10: ACK drive begins only right after an SCL fall.
    assert_ack_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(scl_fall));
    // R10: ACK drive ends only at an SCL fall or a bus condition.
    assert_release_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> $past(scl_fall || start_det || stop_det));
    // R9: a START leaves the engine waiting for a fresh address byte.
    assert_start_resets_phase_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start_det) |-> (ph == PH_DEV && bitcnt == 4'd0));
    // R8: one write strobe per data byte.
    assert_single_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);
endmodule

// File: rtl/xbar_reg_bank.sv
// Configuration registers and their decode into crosspoint control
// lines. Assumes two SEL_W-bit selects fit one 8-bit routing register
// and that N_IN and N_OUT are at most 8.
module xbar_reg_bank #(
    parameter int N_IN  = 8,
    parameter int N_OUT = 6,
    parameter int SEL_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_stb,
    input  logic [7:0]             wr_addr,
    input  logic [7:0]             wr_data,
    output logic [N_OUT*SEL_W-1:0] out_sel,
    output logic [N_OUT-1:0]       out_en,
    output logic [N_IN-1:0]        in_clamp,
    output logic [N_OUT-1:0]       out_gain0db
);
    localparam int N_ROUTE    = (N_OUT + 1) / 2;
    localparam int CLAMP_ADDR = N_ROUTE;
    localparam int GAIN_ADDR  = N_ROUTE + 1;

    logic [N_ROUTE-1:0][7:0] route_q;
    logic [N_IN-1:0]         clamp_q;
    logic [N_OUT-1:0]        gain_q;

    // Register writes; pointers beyond the gain register fall through.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            route_q <= '0;
            clamp_q <= '0;
            gain_q  <= '0;
        end else if (wr_stb) begin
            for (int r = 0; r < N_ROUTE; r++) begin
                if (wr_addr == 8'(r)) route_q[r] <= wr_data;
            end
            if (wr_addr == 8'(CLAMP_ADDR)) clamp_q <= wr_data[N_IN-1:0];
            if (wr_addr == 8'(GAIN_ADDR))  gain_q  <= wr_data[N_OUT-1:0];
        end
    end

    generate
        if (N_OUT < 8) begin : g_gain_pad
            logic unused_gain_bits;
            assign unused_gain_bits = ^wr_data[7:N_OUT];
        end
        if (N_IN < 8) begin : g_clamp_pad
            logic unused_clamp_bits;
            assign unused_clamp_bits = ^wr_data[7:N_IN];
        end
    endgenerate

    // Per-output decode of the select code into input number and enable.
    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        logic [SEL_W-1:0] code;
        logic             legal;
        assign code  = route_q[o/2][(o%2)*SEL_W +: SEL_W];
        assign legal = (code != '0) && (code <= SEL_W'(N_IN));
        assign out_en[o]                  = legal;
        assign out_sel[o*SEL_W +: SEL_W]  = legal ? code : '0;

        // R4: a disabled driver never reports an input.
        assert_off_sel_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
            !out_en[o] |-> (out_sel[o*SEL_W +: SEL_W] == '0));
        // R4: an enabled driver always names a real input.
        assert_on_sel_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
            out_en[o] |-> (out_sel[o*SEL_W +: SEL_W] != '0 &&
                           out_sel[o*SEL_W +: SEL_W] <= SEL_W'(N_IN)));
    end

    assign in_clamp    = clamp_q;
    assign out_gain0db = gain_q;

    // R7: a write beyond the defined registers changes nothing.
    assert_undef_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_addr > 8'(GAIN_ADDR)) |=>
            ($stable(route_q) && $stable(clamp_q) && $stable(gain_q)));
    // R2: leaving reset, every output is off, bias mode, 6 dB.
    assert_reset_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (out_en == '0 && in_clamp == '0 && out_gain0db == '0));
endmodule

// File: rtl/xbar_cfg_slave.sv
// Top of the crosspoint configuration slave: line synchroniser, byte
// engine and register bank. The straps form the top two address bits;
// the lower five come from BASE_ADDR.
module xbar_cfg_slave #(
    parameter int         N_IN      = 8,
    parameter int         N_OUT     = 6,
    parameter int         SEL_W     = 4,
    parameter logic [6:0] BASE_ADDR = 7'h03
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_i,
    input  logic                   sda_i,
    input  logic                   strap_hi,
    input  logic                   strap_lo,
    output logic                   sda_oe,
    output logic [N_OUT*SEL_W-1:0] out_sel,
    output logic [N_OUT-1:0]       out_en,
    output logic [N_IN-1:0]        in_clamp,
    output logic [N_OUT-1:0]       out_gain0db
);
    logic       sda_bit, scl_rise, scl_fall, start_det, stop_det;
    logic       wr_stb;
    logic [7:0] wr_addr, wr_data;
    logic [6:0] dev_addr;

    assign dev_addr = {strap_hi, strap_lo, BASE_ADDR[4:0]};

    xbar_line_sync u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_bit(sda_bit), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    xbar_wr_engine u_engine (
        .clk(clk), .rst_n(rst_n), .dev_addr(dev_addr), .sda_bit(sda_bit),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
        .stop_det(stop_det), .sda_oe(sda_oe), .wr_stb(wr_stb),
        .wr_addr(wr_addr), .wr_data(wr_data)
    );

    xbar_reg_bank #(.N_IN(N_IN), .N_OUT(N_OUT), .SEL_W(SEL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .out_sel(out_sel), .out_en(out_en),
        .in_clamp(in_clamp), .out_gain0db(out_gain0db)
    );
endmodule

// File: tb/xbar_cfg_slave_bench.sv
`timescale 1ns/1ps
// Self-checking bench: drives the serial bus as a controller and checks
// decoded outputs against a register model held in the bench.
module xbar_cfg_slave_bench;
    localparam int Q = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        sda_drv = 1'b1;
    logic        strap_hi = 1'b0, strap_lo = 1'b0;
    logic        sda_oe;
    logic [23:0] out_sel;
    logic [5:0]  out_en;
    logic [7:0]  in_clamp;
    logic [5:0]  out_gain0db;
    logic        sda_line;
    logic        data_high = 1'b0;

    int checks = 0, errors = 0, bus_viol = 0;
    logic [7:0] exp_reg [5];
    logic [7:0] tx [8];

    assign sda_line = sda_drv & ~sda_oe;

    always #2.5 clk = ~clk;

    xbar_cfg_slave u_xbar_cfg_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .strap_hi(strap_hi), .strap_lo(strap_lo), .sda_oe(sda_oe),
        .out_sel(out_sel), .out_en(out_en), .in_clamp(in_clamp),
        .out_gain0db(out_gain0db)
    );

    // R10 monitor: slave must not drive while a data bit is on the bus.
    always @(negedge clk) if (data_high && sda_oe) bus_viol++;

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_drv = 1'b1; wq(Q); scl = 1'b1; wq(Q);
        sda_drv = 1'b0; wq(Q); scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop;
        sda_drv = 1'b0; wq(Q); scl = 1'b1; wq(Q);
        sda_drv = 1'b1; wq(Q);
    endtask

    task automatic send_bit(input logic b);
        sda_drv = b; wq(Q); scl = 1'b1; data_high = 1'b1; wq(2*Q);
        data_high = 1'b0; scl = 1'b0; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_drv = 1'b1; wq(Q); scl = 1'b1; wq(Q);
        ack = !sda_line; wq(Q); scl = 1'b0; wq(Q);
    endtask

    // One transfer: address byte, pointer, n data bytes from tx[].
    task automatic xfer(input logic [7:0] dev, input logic [7:0] ptr, input int n,
                        output logic dev_ack, output logic all_ack);
        logic a;
        bus_start;
        send_byte(dev, dev_ack);
        all_ack = dev_ack;
        send_byte(ptr, a); all_ack &= a;
        for (int i = 0; i < n; i++) begin
            send_byte(tx[i], a); all_ack &= a;
        end
        bus_stop;
        wq(8);
    endtask

    function automatic logic [7:0] dev_byte(input logic hi, input logic lo);
        return {hi, lo, 6'b000110};
    endfunction

    task automatic model_write(input logic [7:0] ptr, input int n);
        for (int i = 0; i < n; i++)
            if (32'(ptr) + i <= 4) exp_reg[32'(ptr) + i] = tx[i];
    endtask

    // Compare every decoded output with the model.
    task automatic check_all(input string tag);
        logic [23:0] es;
        logic [5:0]  ee;
        for (int o = 0; o < 6; o++) begin
            int code;
            code = (exp_reg[o/2] >> (4*(o%2))) & 8'hF;
            ee[o] = (code >= 1 && code <= 8);
            es[o*4 +: 4] = ee[o] ? 4'(code) : 4'd0;
        end
        chk(out_sel == es, {tag, " R3 select"}, 32'(out_sel), 32'(es));
        chk(out_en == ee, {tag, " R4 enable"}, 32'(out_en), 32'(ee));
        chk(in_clamp == exp_reg[3], {tag, " R5 clamp"}, 32'(in_clamp), 32'(exp_reg[3]));
        chk(out_gain0db == exp_reg[4][5:0], {tag, " R6 gain"}, 32'(out_gain0db), 32'(exp_reg[4][5:0]));
    endtask

    initial begin
        #(5.0 * 190000);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic da, aa;
        logic [7:0] dv;
        for (int i = 0; i < 5; i++) exp_reg[i] = 8'h00;
        wq(6); rst_n = 1'b1; wq(4);

        // R2: reset state.
        chk(sda_oe == 1'b0, "R2 sda released", 32'(sda_oe), 0);
        check_all("R2");

        dv = dev_byte(1'b0, 1'b0);
        // R3/R4: every select code on both halves of each routing register.
        for (int r = 0; r < 3; r++) begin
            for (int c = 0; c < 16; c++) begin
                tx[0] = {4'(c), 4'(15 - c)};
                xfer(dv, 8'(r), 1, da, aa);
                chk(aa, "R3 write acked", 32'(aa), 1);
                model_write(8'(r), 1);
                check_all("R3/R4 sweep");
            end
        end
        // R4: one input fanned out to all outputs.
        tx[0] = 8'h33; tx[1] = 8'h33; tx[2] = 8'h33;
        xfer(dv, 8'h00, 3, da, aa); model_write(8'h00, 3);
        check_all("R4 fan-out");

        // R5: walking clamp bit and mixed patterns.
        for (int n = 0; n < 10; n++) begin
            tx[0] = (n < 8) ? 8'(1 << n) : (n == 8 ? 8'hA5 : 8'h00);
            xfer(dv, 8'h03, 1, da, aa); model_write(8'h03, 1);
            check_all("R5 clamp");
        end

        // R6: gain values with unused bits 7:6 set.
        for (int v = 0; v < 64; v += 9) begin
            tx[0] = 8'hC0 | 8'(v);
            xfer(dv, 8'h04, 1, da, aa); model_write(8'h04, 1);
            check_all("R6 gain");
        end
        tx[0] = 8'hFF; xfer(dv, 8'h04, 1, da, aa); model_write(8'h04, 1);
        check_all("R6 gain all");

        // R7: undefined pointers acked, nothing changes.
        tx[0] = 8'hFF;
        xfer(dv, 8'h05, 1, da, aa);
        chk(aa, "R7 ack at 0x05", 32'(aa), 1); check_all("R7 0x05");
        tx[0] = 8'h00;
        xfer(dv, 8'hFF, 1, da, aa);
        chk(aa, "R7 ack at 0xFF", 32'(aa), 1); check_all("R7 0xFF");

        // R8: auto-increment across all registers, then past the end.
        tx[0] = 8'h21; tx[1] = 8'h43; tx[2] = 8'h65; tx[3] = 8'h5A; tx[4] = 8'h15;
        xfer(dv, 8'h00, 5, da, aa);
        chk(aa, "R8 burst acked", 32'(aa), 1);
        model_write(8'h00, 5); check_all("R8 burst");
        tx[0] = 8'h2A; tx[1] = 8'hFF; tx[2] = 8'hFF;
        xfer(dv, 8'h04, 3, da, aa);
        model_write(8'h04, 3); check_all("R8 burst past end");

        // R1: strap-driven address match, mismatch, read request.
        for (int s = 0; s < 4; s++) begin
            strap_hi = s[1]; strap_lo = s[0]; wq(4);
            tx[0] = 8'(8'h11 * (s + 1));
            xfer(dev_byte(s[1], s[0]), 8'h03, 1, da, aa);
            chk(da, "R1 match acked", 32'(da), 1);
            model_write(8'h03, 1);
            check_all("R1 match");
            tx[0] = 8'h00;
            xfer(dev_byte(~s[1], s[0]), 8'h03, 1, da, aa);
            chk(!da, "R1 mismatch not acked", 32'(da), 0);
            check_all("R1 mismatch");
            xfer(dev_byte(s[1], s[0]) | 8'h01, 8'h03, 1, da, aa);
            chk(!da, "R1 read not acked", 32'(da), 0);
            check_all("R1 read");
        end
        strap_hi = 1'b0; strap_lo = 1'b0; wq(4);

        // R9: repeated start after the pointer, and in mid-byte.
        bus_start; send_byte(dv, da); send_byte(8'h00, aa);
        bus_start; send_byte(dv, da);
        chk(da, "R9 address after restart", 32'(da), 1);
        send_byte(8'h01, aa); send_byte(8'h78, aa);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        bus_start; send_byte(dv, da);
        chk(da, "R9 address after cut byte", 32'(da), 1);
        send_byte(8'h02, aa); send_byte(8'h87, aa);
        bus_stop; wq(8);
        exp_reg[1] = 8'h78; exp_reg[2] = 8'h87;
        check_all("R9 restart");

        // R10: no drive during any data bit over the whole run.
        chk(bus_viol == 0, "R10 sda driven in data bit", 32'(bus_viol), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule